// File: doc/BRIEF.md
# Dual-Geometry Lookup-Table RAM Cell

This block is one logic cell built around two 16-entry single-bit lookup tables, named F and G. Each table is addressed by its own four inputs and read combinationally. A mode input decides whether the tables act as fixed logic, loaded once through a preload port, or as user read/write memory. The memory can be one 16-word by 2-bit array, or one 32-word by 1-bit array in which a fifth address bit picks the table.

Three shared control inputs change meaning with the mode. In logic mode `ctl_w` is a synchronous clear for the output flip-flops, and `ctl_h` and `ctl_d` are plain signals. In the 16x2 mode `ctl_w` is the write enable, `ctl_d` is the data bit for F and `ctl_h` is the data bit for G. In the 32x1 mode `ctl_w` is the write enable, `ctl_d` is the single data bit and `ctl_h` is the fifth address bit.

A third function H combines F, G and `ctl_h` through an 8-entry truth table. In the 32x1 mode H becomes the read multiplexer. Two flip-flops each capture F, G, H or `ctl_d`. The rest of the cell works the same way in every mode.

Top module: `lut_ram_cell`

## Requirements
- R1: `f_out` always equals F[`f_in`] and `g_out` always equals G[`g_in`], combinationally. `mode_sel` codes: 0 is logic, 1 is 16x2 RAM, 2 is 32x1 RAM, 3 behaves as logic.
- R2: In logic mode (codes 0 and 3), the inputs `ctl_w`, `ctl_d` and `ctl_h` never alter either table.
- R3: In 16x2 mode, a rising edge with `ctl_w`=1 stores `ctl_d` into F[`f_in`] and `ctl_h` into G[`g_in`].
- R4: In 32x1 mode, a rising edge with `ctl_w`=1 stores `ctl_d` into F[`f_in`] when `ctl_h`=0, or into G[`g_in`] when `ctl_h`=1. The other table is left unchanged.
- R5: A written value appears on the read outputs only after the writing edge. A flip-flop that captures a table output on that same edge gets the old value.
- R6: In logic and 16x2 modes, `h_out` = `h_cfg`[{`ctl_h`,`g_out`,`f_out`}], where `ctl_h` is the most significant bit of the index.
- R7: In 32x1 mode, `h_out` = `ctl_h` ? `g_out` : `f_out`, and `h_cfg` is ignored.
- R8: On each rising edge, `q1` and `q2` load the source chosen by `q1_sel` and `q2_sel`: 0 selects F, 1 selects G, 2 selects H, 3 selects `ctl_d`.
- R9: With `rst` high, `q1` and `q2` are 0 after the edge. Table contents are not reset.
- R10: In logic mode, `ctl_w`=1 clears `q1` and `q2` at the edge. In the RAM modes `ctl_w` never clears them.
- R11: `pl_en`=1 writes `pl_data` into table `pl_sel` (0 is F, 1 is G) at `pl_addr` on the edge, in any mode. For that table it takes priority over a user write on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the flip-flops |
| mode_sel | input | 2 | Cell mode code |
| f_in | input | 4 | Address of table F |
| g_in | input | 4 | Address of table G |
| ctl_h | input | 1 | H input, G data (16x2) or fifth address bit (32x1) |
| ctl_d | input | 1 | Direct data, F data (16x2) or data bit (32x1) |
| ctl_w | input | 1 | Flip-flop clear (logic) or write enable (RAM) |
| h_cfg | input | 8 | Truth table of H |
| q1_sel | input | 2 | Source select of flip-flop 1 |
| q2_sel | input | 2 | Source select of flip-flop 2 |
| pl_en | input | 1 | Preload write strobe |
| pl_sel | input | 1 | Preload target table |
| pl_addr | input | 4 | Preload address |
| pl_data | input | 1 | Preload data bit |
| f_out | output | 1 | Combinational F read |
| g_out | output | 1 | Combinational G read |
| h_out | output | 1 | Combinational H result |
| q1 | output | 1 | Flip-flop 1 |
| q2 | output | 1 | Flip-flop 2 |

## Verification
The assertions assume that every table entry has been preloaded while `rst` is high, so reads are never unknown once reset ends. They also assume the preload port is idle whenever a property checks user writes or unchanged contents. The bench keeps to this. It fills all 32 entries during reset, and it raises `pl_en` only in the final priority case, after the swept checks. Each read sweep covers all addresses, and each write sweep covers every address with both values of the selecting control bit.

// File: rtl/lutcell_pkg.sv
package lutcell_pkg;
  typedef enum logic [1:0] {
    MODE_LOGIC = 2'd0,
    MODE_R16X2 = 2'd1,
    MODE_R32X1 = 2'd2,
    MODE_RSVD  = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    SRC_F = 2'd0,
    SRC_G = 2'd1,
    SRC_H = 2'd2,
    SRC_D = 2'd3
  } src_e;

  localparam int H_IN  = 3;
  localparam int H_W   = 2 ** H_IN;
  localparam int N_TBL = 2;
  localparam int N_FF  = 2;
endpackage

// File: rtl/lut_table.sv
module lut_table #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              wr_data,
  input  logic              pl_en,
  input  logic [ADDR_W-1:0] pl_addr,
  input  logic              pl_data,
  output logic              rd_data
);
  localparam int DEPTH = 2 ** ADDR_W;

  logic mem [DEPTH];

  always_ff @(posedge clk) begin
    if (pl_en)
      mem[pl_addr] <= pl_data;
    else if (wr_en)
      mem[addr] <= wr_data;
  end

  assign rd_data = mem[addr];
endmodule

// File: rtl/lut_cell_hfn.sv
module lut_cell_hfn
  import lutcell_pkg::*;
(
  input  logic           mux_mode,
  input  logic [H_W-1:0] cfg,
  input  logic           f,
  input  logic           g,
  input  logic           h_in,
  output logic           h
);
  always_comb begin
    if (mux_mode)
      h = h_in ? g : f;
    else
      h = cfg[{h_in, g, f}];
  end
endmodule

// File: rtl/lut_cell_ff.sv
module lut_cell_ff
  import lutcell_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic [1:0] sel,
  input  logic       f,
  input  logic       g,
  input  logic       h,
  input  logic       d,
  output logic       q
);
  logic nxt;

  always_comb begin
    unique case (src_e'(sel))
      SRC_F:   nxt = f;
      SRC_G:   nxt = g;
      SRC_H:   nxt = h;
      default: nxt = d;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clr)
      q <= 1'b0;
    else
      q <= nxt;
  end
endmodule

// File: rtl/lut_ram_cell.sv
module lut_ram_cell
  import lutcell_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode_sel,
  input  logic [ADDR_W-1:0] f_in,
  input  logic [ADDR_W-1:0] g_in,
  input  logic              ctl_h,
  input  logic              ctl_d,
  input  logic              ctl_w,
  input  logic [H_W-1:0]    h_cfg,
  input  logic [1:0]        q1_sel,
  input  logic [1:0]        q2_sel,
  input  logic              pl_en,
  input  logic              pl_sel,
  input  logic [ADDR_W-1:0] pl_addr,
  input  logic              pl_data,
  output logic              f_out,
  output logic              g_out,
  output logic              h_out,
  output logic              q1,
  output logic              q2
);
  mode_e mode;
  logic  is_logic, is_r16, is_r32;

  assign mode     = mode_e'(mode_sel);
  assign is_r16   = (mode == MODE_R16X2);
  assign is_r32   = (mode == MODE_R32X1);
  assign is_logic = !is_r16 && !is_r32;

  logic [ADDR_W-1:0] t_addr [N_TBL];
  logic              t_we   [N_TBL];
  logic              t_wd   [N_TBL];
  logic              t_rd   [N_TBL];

  assign t_addr[0] = f_in;
  assign t_addr[1] = g_in;

  // Control pins reinterpreted per mode: table 0 is F, table 1 is G
  always_comb begin
    t_we[0] = 1'b0;
    t_we[1] = 1'b0;
    t_wd[0] = ctl_d;
    t_wd[1] = ctl_d;
    if (is_r16) begin
      t_we[0] = ctl_w;
      t_we[1] = ctl_w;
      t_wd[1] = ctl_h;
    end else if (is_r32) begin
      t_we[0] = ctl_w && !ctl_h;
      t_we[1] = ctl_w && ctl_h;
    end
  end

  for (genvar t = 0; t < N_TBL; t++) begin : g_tbl
    lut_table #(.ADDR_W(ADDR_W)) i_tbl (
      .clk     (clk),
      .addr    (t_addr[t]),
      .wr_en   (t_we[t]),
      .wr_data (t_wd[t]),
      .pl_en   (pl_en && (pl_sel == 1'(t))),
      .pl_addr (pl_addr),
      .pl_data (pl_data),
      .rd_data (t_rd[t])
    );
  end

  assign f_out = t_rd[0];
  assign g_out = t_rd[1];

  lut_cell_hfn i_hfn (
    .mux_mode (is_r32),
    .cfg      (h_cfg),
    .f        (t_rd[0]),
    .g        (t_rd[1]),
    .h_in     (ctl_h),
    .h        (h_out)
  );

  logic [1:0] ff_sel [N_FF];
  logic       ff_q   [N_FF];

  assign ff_sel[0] = q1_sel;
  assign ff_sel[1] = q2_sel;

  for (genvar k = 0; k < N_FF; k++) begin : g_ff
    lut_cell_ff i_ff (
      .clk (clk),
      .rst (rst),
      .clr (is_logic && ctl_w),
      .sel (ff_sel[k]),
      .f   (t_rd[0]),
      .g   (t_rd[1]),
      .h   (h_out),
      .d   (ctl_d),
      .q   (ff_q[k])
    );
  end

  assign q1 = ff_q[0];
  assign q2 = ff_q[1];
endmodule

// File: rtl/lut_ram_cell_chk.sv
module lut_ram_cell_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        mode_sel,
  input logic [ADDR_W-1:0] f_in,
  input logic              ctl_h,
  input logic              ctl_d,
  input logic              ctl_w,
  input logic [1:0]        q1_sel,
  input logic              pl_en,
  input logic              f_out,
  input logic              g_out,
  input logic              h_out,
  input logic              q1,
  input logic              q2
);
  logic lg;
  assign lg = (mode_sel == 2'd0) || (mode_sel == 2'd3);

  function automatic logic pick(logic [1:0] s, logic f, logic g, logic h, logic d);
    case (s)
      2'd0:    return f;
      2'd1:    return g;
      2'd2:    return h;
      default: return d;
    endcase
  endfunction

  AST_MUX_32X1: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'd2) |-> (h_out == (ctl_h ? g_out : f_out))); // R7

  AST_Q1_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    !(lg && ctl_w) |=> (q1 == pick($past(q1_sel), $past(f_out), $past(g_out),
                                   $past(h_out), $past(ctl_d)))); // R8

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!q1 && !q2)); // R9

  AST_LOGIC_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (lg && ctl_w) |=> (!q1 && !q2)); // R10

  AST_LOGIC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (lg && !pl_en) |=> ((f_in != $past(f_in)) || (f_out == $past(f_out)))); // R2

  AST_WRITE_16X2: assert property (@(posedge clk) disable iff (rst)
    ((mode_sel == 2'd1) && ctl_w && !pl_en) |=>
      ((f_in != $past(f_in)) || (f_out == $past(ctl_d)))); // R3
endmodule

bind lut_ram_cell lut_ram_cell_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .mode_sel (mode_sel),
  .f_in     (f_in),
  .ctl_h    (ctl_h),
  .ctl_d    (ctl_d),
  .ctl_w    (ctl_w),
  .q1_sel   (q1_sel),
  .pl_en    (pl_en),
  .f_out    (f_out),
  .g_out    (g_out),
  .h_out    (h_out),
  .q1       (q1),
  .q2       (q2)
);

// File: tb/test_lut_ram_cell.sv
`timescale 1ns/1ps
module test_lut_ram_cell;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] mode_sel;
  logic [3:0] f_in, g_in;
  logic       ctl_h, ctl_d, ctl_w;
  logic [7:0] h_cfg;
  logic [1:0] q1_sel, q2_sel;
  logic       pl_en, pl_sel, pl_data;
  logic [3:0] pl_addr;
  logic       f_out, g_out, h_out, q1, q2;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 0;
  logic mf [16];
  logic mg [16];

  always #2.5 clk = ~clk;

  lut_ram_cell i_lut_ram_cell (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .f_in(f_in), .g_in(g_in),
    .ctl_h(ctl_h), .ctl_d(ctl_d), .ctl_w(ctl_w), .h_cfg(h_cfg),
    .q1_sel(q1_sel), .q2_sel(q2_sel), .pl_en(pl_en), .pl_sel(pl_sel),
    .pl_addr(pl_addr), .pl_data(pl_data), .f_out(f_out), .g_out(g_out),
    .h_out(h_out), .q1(q1), .q2(q2)
  );

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic sel_val(logic [1:0] s, logic f, logic g, logic h, logic d);
    case (s)
      2'd0: return f;
      2'd1: return g;
      2'd2: return h;
      default: return d;
    endcase
  endfunction

  function automatic logic h_exp(logic [1:0] m, logic hi, logic g, logic f);
    if (m == 2'd2) return hi ? g : f;
    return h_cfg[{hi, g, f}];
  endfunction

  // full read sweep against the model in current mode
  task automatic read_sweep(string tf, string tg, string th);
    for (int a = 0; a < 16; a++) begin
      @(negedge clk);
      f_in = 4'(a); g_in = 4'(15 - a); ctl_w = 1'b0; ctl_h = a[0]; ctl_d = a[1];
      #1;
      chk(tf, f_out, mf[a]);
      chk(tg, g_out, mg[15 - a]);
      chk(th, h_out, h_exp(mode_sel, ctl_h, mg[15 - a], mf[a]));
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1; mode_sel = 2'd0; f_in = 0; g_in = 0; ctl_h = 0; ctl_d = 0; ctl_w = 0;
    h_cfg = 8'b1001_0110; q1_sel = 2'd2; q2_sel = 2'd3;
    pl_en = 0; pl_sel = 0; pl_addr = 0; pl_data = 0;

    // R11: preload all entries during reset
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      pl_en = 1; pl_sel = i[4]; pl_addr = i[3:0];
      pl_data = i[4] ? (i[3:0] > 4'd3) : (i[0] ^ i[2]);
      if (i[4]) mg[i[3:0]] = pl_data; else mf[i[3:0]] = pl_data;
    end
    @(negedge clk); pl_en = 0;
    @(negedge clk);
    chk("R9 q1 reset", q1, 1'b0);
    chk("R9 q2 reset", q2, 1'b0);
    rst = 0;
    read_sweep("R11 preload F", "R11 preload G", "R6 h logic");

    // R1 R6 R8: logic mode read and capture sweep
    for (int a = 0; a < 16; a++) begin
      logic e1, e2;
      @(negedge clk);
      f_in = 4'(a); g_in = 4'(a ^ 9); ctl_h = a[2]; ctl_d = a[0]; ctl_w = 0;
      q1_sel = 2'(a); q2_sel = 2'(a + 1);
      #1;
      chk("R1 f read", f_out, mf[a]);
      chk("R1 g read", g_out, mg[a ^ 9]);
      e1 = sel_val(q1_sel, mf[a], mg[a ^ 9], h_exp(2'd0, ctl_h, mg[a ^ 9], mf[a]), ctl_d);
      e2 = sel_val(q2_sel, mf[a], mg[a ^ 9], h_exp(2'd0, ctl_h, mg[a ^ 9], mf[a]), ctl_d);
      @(posedge clk); #1;
      chk("R8 q1 capture", q1, e1);
      chk("R8 q2 capture", q2, e2);
    end

    // R10 R2: logic-mode clear, writes ignored (codes 0 and 3)
    for (int a = 0; a < 16; a++) begin
      @(negedge clk);
      mode_sel = a[0] ? 2'd3 : 2'd0;
      f_in = 4'(a); g_in = 4'(a); ctl_w = 1; ctl_d = ~mf[a]; ctl_h = ~mg[a];
      q1_sel = 2'd3; q2_sel = 2'd2;
      @(posedge clk); #1;
      chk("R10 q1 clear", q1, 1'b0);
      chk("R10 q2 clear", q2, 1'b0);
    end
    mode_sel = 2'd0;
    read_sweep("R2 F kept", "R2 G kept", "R6 h logic2");

    // R3 R5 R10: 16x2 writes
    mode_sel = 2'd1; q1_sel = 2'd0; q2_sel = 2'd3;
    for (int a = 0; a < 16; a++) begin
      logic oldf, nf, ng;
      @(negedge clk);
      f_in = 4'(a); g_in = 4'(a ^ 5); ctl_w = 1;
      nf = ~mf[a]; ng = a[0] ^ a[3];
      ctl_d = nf; ctl_h = ng;
      #1;
      oldf = mf[a];
      chk("R5 f old before edge", f_out, oldf);
      @(posedge clk); #1;
      mf[a] = nf; mg[a ^ 5] = ng;
      chk("R3 f written", f_out, nf);
      chk("R3 g written", g_out, ng);
      chk("R5 q1 got old", q1, oldf);
      chk("R10 no clear in RAM", q2, nf);
    end
    read_sweep("R3 F readback", "R3 G readback", "R6 h 16x2");

    // R4 R5 R7: 32x1 writes
    mode_sel = 2'd2;
    for (int i = 0; i < 32; i++) begin
      logic nd;
      logic [3:0] a;
      @(negedge clk);
      a = i[3:0];
      f_in = a; g_in = a; ctl_h = i[4]; ctl_w = 1;
      nd = i[0] ^ i[4] ^ i[2] ^ 1'b1;
      ctl_d = nd;
      #1;
      chk("R7 mux before edge", h_out, i[4] ? mg[a] : mf[a]);
      @(posedge clk); #1;
      if (i[4]) mg[a] = nd; else mf[a] = nd;
      chk("R4 selected table", h_out, nd);
      chk("R4 F state", f_out, mf[a]);
      chk("R4 G state", g_out, mg[a]);
    end
    h_cfg = 8'h00;
    read_sweep("R4 F readback", "R4 G readback", "R7 h mux");

    // R11: preload beats user write on its table
    @(negedge clk);
    mode_sel = 2'd1; f_in = 4'd3; g_in = 4'd7; ctl_w = 1; ctl_d = 0; ctl_h = ~mg[7];
    pl_en = 1; pl_sel = 0; pl_addr = 4'd3; pl_data = 1;
    @(posedge clk); #1;
    mf[3] = 1; mg[7] = ctl_h;
    chk("R11 preload wins F", f_out, 1'b1);
    chk("R11 G still written", g_out, mg[7]);
    @(negedge clk);
    mode_sel = 2'd2; f_in = 4'd8; g_in = 4'd8; ctl_h = 0; ctl_d = ~mf[8];
    pl_sel = 1; pl_addr = 4'd8; pl_data = ~mg[8];
    @(posedge clk); #1;
    mf[8] = ctl_d; mg[8] = pl_data;
    chk("R11 preload G in 32x1", g_out, mg[8]);
    chk("R4 F written alongside", f_out, mf[8]);
    @(negedge clk); pl_en = 0; ctl_w = 0;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule